// File: doc/BRIEF.md
# DMA Address Translation Unit

This block sits between a device's DMA engine and host memory. It turns each IO address issued by a device into a host address. The lookup uses a flat table of 64-bit translation entries that lives in host memory. The IO page number, which is the address above bit 11, indexes that table directly. The unit builds the entry's address from a programmable table base. It fetches the entry over a single-beat memory read port. It then checks the direction against the entry's read and write permission bits, and it checks the entry's bus-isolation hub identifier against the configured bus number. The result is either a host address or a fault. On a fault the unit records the IO address that caused it.

An eight-slot, fully associative translation cache keeps recent entries. A request that hits the cache is answered in the next cycle. A request that misses holds off further requests until its table read returns. Slots are refilled in round-robin order. Software cannot drop a single cached entry. The only way to invalidate is a whole-cache flush, which the unit accepts only while no table read is in flight.

Top module: `dma_xlate_unit`

## Requirements
- R1: After a synchronous reset, `rsp_valid`, `mem_rd_req` and `flush_done` are low, `fault_addr` is zero, and `req_ready` is high.
- R2: On a miss, exactly one table read is issued, with `mem_rd_addr` = `cfg_tbl_base` + 8 × (IO page number), where the IO page number is `req_addr[31:12]`.
- R3: With LSB-0 numbering of a 64-bit entry, the real page number is bits 47:12, the hub identifier is bits 7:2, write permission is bit 1 and read permission is bit 0. A granted request returns `rsp_haddr` = {real page number, `req_addr[11:0]`} with `rsp_fault` low.
- R4: A read needs entry bit 0 set and a write needs entry bit 1 set. Otherwise the response faults. An entry with both bits clear faults for either direction.
- R5: When the entry's hub identifier differs from `cfg_bus_id`, the response faults.
- R6: A request whose IO page number is greater than or equal to `cfg_tbl_limit` faults in the cycle after acceptance, and no table read is issued.
- R7: A faulting response drives `rsp_haddr` to zero. In the same cycle, `fault_addr` takes the full IO address of that request and keeps it until the next fault.
- R8: A cache hit is answered in the cycle after acceptance, with no table read. A miss is answered in the cycle after `mem_rd_rvalid`, and `req_ready` stays low until then.
- R9: The cache holds 8 entries. After reset or a flush, fills go to slot 0, then 1, and so on, wrapping back to slot 0. A ninth distinct page therefore evicts the oldest fill.
- R10: An entry with both permission bits clear is never cached, so repeating the request fetches it again. Entries that are valid but deny the requested direction are cached.
- R11: While `flush_req` is high, `req_ready` is low. A flush is taken only when no table read is outstanding. It invalidates every slot, so a later request to a page that was cached fetches a fresh entry. `flush_done` pulses for one cycle after the flush is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tbl_base | input | 48 | Host byte address of table entry 0 |
| cfg_tbl_limit | input | 21 | Number of table entries; pages at or above this value fault |
| cfg_bus_id | input | 6 | Bus number that entries' hub identifier must match |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_addr | input | 32 | IO (DMA) address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_haddr | output | 48 | Translated host address (zero on fault) |
| fault_addr | output | 32 | IO address of the latest faulting request |
| mem_rd_req | output | 1 | One-cycle table read request |
| mem_rd_addr | output | 48 | Host address of the entry being read |
| mem_rd_rvalid | input | 1 | Table read data valid |
| mem_rd_rdata | input | 64 | Table entry returned |
| flush_req | input | 1 | Request to invalidate the whole cache |
| flush_done | output | 1 | One-cycle pulse after the flush is taken |

## Verification
The scoreboard sends requests in several patterns: a first touch followed by a repeat to the same page, which separates the miss path from the hit path by both latency and fetch count; reads and writes against read-only, write-only, invalid and foreign-hub entries, which separates each fault cause; and pages on either side of the table limit, which shows that an out-of-range page faults without a table read. A stream of nine distinct pages, followed by revisits, reveals the round-robin victim order. A table entry is rewritten behind the cache and read both before and after a flush, which tells stale data from fresh data. A flush raised while a miss is in flight shows that the flush waits for the outstanding read to finish.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int ENT_SHIFT  = 3;
  localparam int HADDR_W    = 48;
  localparam int RPN_W      = HADDR_W - PAGE_SHIFT;
  localparam int HUB_W      = 6;
  localparam int ENTRY_W    = 64;

  typedef struct packed {
    logic [RPN_W-1:0] rpn;
    logic [HUB_W-1:0] hub;
    logic             wr_ok;
    logic             rd_ok;
  } xlate_t;

  function automatic xlate_t unpack_entry(input logic [ENTRY_W-1:0] e);
    xlate_t x;
    x.rpn   = e[PAGE_SHIFT+RPN_W-1:PAGE_SHIFT];
    x.hub   = e[HUB_W+1:2];
    x.wr_ok = e[1];
    x.rd_ok = e[0];
    return x;
  endfunction
endpackage

// File: rtl/dxu_addr_gen.sv
module dxu_addr_gen
  import dxu_pkg::*;
#(
  parameter int IOPN_W = 20
) (
  input  logic [HADDR_W-1:0] tbl_base,
  input  logic [IOPN_W:0]    tbl_limit,
  input  logic [IOPN_W-1:0]  page,
  output logic [HADDR_W-1:0] ent_addr,
  output logic               over_limit
);
  localparam int PAD_W = HADDR_W - IOPN_W - ENT_SHIFT;

  assign ent_addr   = tbl_base + {{PAD_W{1'b0}}, page, {ENT_SHIFT{1'b0}}};
  assign over_limit = ({1'b0, page} >= tbl_limit);
endmodule

// File: rtl/dxu_perm.sv
module dxu_perm
  import dxu_pkg::*;
#(
  parameter bit HUB_CHECK = 1'b1
) (
  input  xlate_t           ent,
  input  logic             is_write,
  input  logic [HUB_W-1:0] bus_id,
  output logic             grant
);
  logic dir_ok;
  logic hub_ok;

  assign dir_ok = is_write ? ent.wr_ok : ent.rd_ok;

  generate
    if (HUB_CHECK) begin : g_hub
      assign hub_ok = (ent.hub == bus_id);
    end else begin : g_nohub
      logic unused_bus;
      assign unused_bus = ^bus_id;
      assign hub_ok = 1'b1;
    end
  endgenerate

  assign grant = dir_ok && hub_ok;
endmodule

// File: rtl/dxu_tlb.sv
module dxu_tlb
  import dxu_pkg::*;
#(
  parameter int TAG_W = 20,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output xlate_t           lk_data,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  xlate_t           fill_data,
  input  logic             flush
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0] vld;
  logic [TAG_W-1:0] tags [DEPTH];
  xlate_t           ents [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [DEPTH-1:0] hv;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign hv[i] = vld[i] && (tags[i] == lk_tag);
    end
  endgenerate

  assign lk_hit = |hv;

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hv[i]) lk_data = xlate_t'(lk_data | ents[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (fill_en) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tags[ptr] <= fill_tag;
      ents[ptr] <= fill_data;
    end
  end
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
  import dxu_pkg::*;
#(
  parameter int IOA_W     = 32,
  parameter int TLB_DEPTH = 8,
  parameter bit HUB_CHECK = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [47:0]        cfg_tbl_base,
  input  logic [IOA_W-12:0]  cfg_tbl_limit,
  input  logic [5:0]         cfg_bus_id,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IOA_W-1:0]   req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [47:0]        rsp_haddr,
  output logic [IOA_W-1:0]   fault_addr,
  output logic               mem_rd_req,
  output logic [47:0]        mem_rd_addr,
  input  logic               mem_rd_rvalid,
  input  logic [63:0]        mem_rd_rdata,
  input  logic               flush_req,
  output logic               flush_done
);
  localparam int IOPN_W = IOA_W - PAGE_SHIFT;

  typedef enum logic {S_IDLE, S_WAIT} st_t;
  st_t st;

  logic [IOA_W-1:0]   q_addr;
  logic               q_write;
  logic [IOPN_W-1:0]  req_pg;
  logic [HADDR_W-1:0] ent_addr;
  logic               over;
  logic               hit;
  xlate_t             hit_ent;
  xlate_t             fetched;
  xlate_t             chk_ent;
  logic               chk_wr;
  logic               grant;
  logic               accept;
  logic               flush_go;
  logic               fill_en;

  assign req_pg    = req_addr[IOA_W-1:PAGE_SHIFT];
  assign req_ready = (st == S_IDLE) && !flush_req;
  assign accept    = req_valid && req_ready;
  assign flush_go  = flush_req && (st == S_IDLE);
  assign fetched   = unpack_entry(mem_rd_rdata);
  assign fill_en   = (st == S_WAIT) && mem_rd_rvalid && (fetched.rd_ok || fetched.wr_ok);
  assign chk_ent   = (st == S_WAIT) ? fetched : hit_ent;
  assign chk_wr    = (st == S_WAIT) ? q_write : req_write;

  dxu_addr_gen #(.IOPN_W(IOPN_W)) u_agen (
    .tbl_base   (cfg_tbl_base),
    .tbl_limit  (cfg_tbl_limit),
    .page       (req_pg),
    .ent_addr   (ent_addr),
    .over_limit (over)
  );

  dxu_tlb #(.TAG_W(IOPN_W), .DEPTH(TLB_DEPTH)) u_tlb (
    .clk       (clk),
    .rst       (rst),
    .lk_tag    (req_pg),
    .lk_hit    (hit),
    .lk_data   (hit_ent),
    .fill_en   (fill_en),
    .fill_tag  (q_addr[IOA_W-1:PAGE_SHIFT]),
    .fill_data (fetched),
    .flush     (flush_go)
  );

  dxu_perm #(.HUB_CHECK(HUB_CHECK)) u_perm (
    .ent      (chk_ent),
    .is_write (chk_wr),
    .bus_id   (cfg_bus_id),
    .grant    (grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_haddr   <= '0;
      fault_addr  <= '0;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      flush_done  <= 1'b0;
      q_addr      <= '0;
      q_write     <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      mem_rd_req <= 1'b0;
      flush_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (flush_go) begin
            flush_done <= 1'b1;
          end else if (accept) begin
            if (over || (hit && !grant)) begin
              rsp_valid  <= 1'b1;
              rsp_fault  <= 1'b1;
              rsp_haddr  <= '0;
              fault_addr <= req_addr;
            end else if (hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_haddr <= {hit_ent.rpn, req_addr[PAGE_SHIFT-1:0]};
            end else begin
              mem_rd_req  <= 1'b1;
              mem_rd_addr <= ent_addr;
              q_addr      <= req_addr;
              q_write     <= req_write;
              st          <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (mem_rd_rvalid) begin
            rsp_valid <= 1'b1;
            st        <= S_IDLE;
            if (grant) begin
              rsp_fault <= 1'b0;
              rsp_haddr <= {fetched.rpn, q_addr[PAGE_SHIFT-1:0]};
            end else begin
              rsp_fault  <= 1'b1;
              rsp_haddr  <= '0;
              fault_addr <= q_addr;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dxu_chk.sv
module dxu_chk #(
  parameter int IOA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [IOA_W-1:0]  req_addr,
  input logic [IOA_W-12:0] cfg_tbl_limit,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [47:0]       rsp_haddr,
  input logic              mem_rd_req,
  input logic              mem_rd_rvalid,
  input logic              flush_req,
  input logic              flush_done
);
  logic [IOA_W-1:0] acc_addr;
  logic             busy_q;
  logic             acc;
  logic             acc_over;

  assign acc      = req_valid && req_ready;
  assign acc_over = acc && ({1'b0, req_addr[IOA_W-1:12]} >= cfg_tbl_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_addr <= '0;
      busy_q   <= 1'b0;
    end else begin
      if (acc) acc_addr <= req_addr;
      if (mem_rd_req) busy_q <= 1'b1;
      else if (mem_rd_rvalid) busy_q <= 1'b0;
    end
  end

  // R7: fault responses carry no host address
  p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_haddr == '0);

  // R3: byte offset passes through
  p_offset_pass_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_fault |-> rsp_haddr[11:0] == acc_addr[11:0]);

  // R6: out-of-range page never fetches
  p_limit_nofetch_r6: assert property (@(posedge clk) disable iff (rst)
    acc_over |=> !mem_rd_req);

  // R8: accepted request either answers or fetches in the next cycle
  p_next_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    acc |=> (rsp_valid || mem_rd_req));

  // R8: no new request while a table read is in flight
  p_busy_noready_r8: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !req_ready);

  // R2: table read strobe lasts one cycle
  p_fetch_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |=> !mem_rd_req);

  // R11: flush is taken only with no read outstanding
  p_flush_idle_r11: assert property (@(posedge clk) disable iff (rst)
    flush_done |-> ($past(flush_req) && !$past(busy_q)));

  // R11: requests held off during flush
  p_flush_block_r11: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> !req_ready);
endmodule

bind dma_xlate_unit dxu_chk #(.IOA_W(IOA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .cfg_tbl_limit (cfg_tbl_limit),
  .rsp_valid     (rsp_valid),
  .rsp_fault     (rsp_fault),
  .rsp_haddr     (rsp_haddr),
  .mem_rd_req    (mem_rd_req),
  .mem_rd_rvalid (mem_rd_rvalid),
  .flush_req     (flush_req),
  .flush_done    (flush_done)
);

// File: tb/dma_xlate_unit_tb.sv
module dma_xlate_unit_tb;
  localparam logic [47:0] BASE  = 48'h0000_8000_0000;
  localparam logic [5:0]  BUS   = 6'h15;
  localparam logic [20:0] LIMIT = 21'd40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_fault;
  logic [47:0] rsp_haddr;
  logic [31:0] fault_addr;
  logic        mem_rd_req;
  logic [47:0] mem_rd_addr;
  logic        mem_rd_rvalid = 1'b0;
  logic [63:0] mem_rd_rdata = '0;
  logic        flush_req = 1'b0;
  logic        flush_done;

  always #4 clk = ~clk;

  dma_xlate_unit u_dut (
    .clk(clk), .rst(rst), .cfg_tbl_base(BASE), .cfg_tbl_limit(LIMIT), .cfg_bus_id(BUS),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_haddr(rsp_haddr), .fault_addr(fault_addr),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_rvalid(mem_rd_rvalid),
    .mem_rd_rdata(mem_rd_rdata), .flush_req(flush_req), .flush_done(flush_done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sent = 0;
  int rcvd = 0;
  int fetch_cnt = 0;
  logic [47:0] last_faddr = '0;
  logic [63:0] tmem [64];

  logic        q_fault [$];
  logic [47:0] q_haddr [$];
  int          q_fetch [$];
  logic [31:0] q_addr  [$];
  int          q_cyc   [$];
  string       q_tag   [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] mk(input logic [35:0] rpn, input logic [5:0] hub,
                                     input logic w, input logic r);
    return {16'h0, rpn, 4'h0, hub, w, r};
  endfunction

  function automatic logic [35:0] rpn_of(input int p);
    return 36'h0ABC_00000 + 36'(p);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // table memory model: answers two cycles after the strobe
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        logic [47:0] off;
        off = (mem_rd_addr - BASE) >> 3;
        repeat (2) @(negedge clk);
        mem_rd_rdata  = (off < 64) ? tmem[off[5:0]] : 64'h0;
        mem_rd_rvalid = 1'b1;
        @(negedge clk);
        mem_rd_rvalid = 1'b0;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd_req) begin
        fetch_cnt++;
        last_faddr = mem_rd_addr;
      end
      if (rsp_valid) begin
        rcvd++;
        if (q_tag.size() == 0) begin
          chk(1'b0, "unexpected response", 64'(rsp_haddr), 64'h0);
        end else begin
          logic ef; logic [47:0] eh; int efc; logic [31:0] ea; int ec; string t;
          ef = q_fault.pop_front(); eh = q_haddr.pop_front(); efc = q_fetch.pop_front();
          ea = q_addr.pop_front(); ec = q_cyc.pop_front(); t = q_tag.pop_front();
          chk(rsp_fault == ef, {t, " fault"}, 64'(rsp_fault), 64'(ef));
          chk(rsp_haddr == eh, {t, " haddr"}, 64'(rsp_haddr), 64'(eh));
          chk(fetch_cnt == efc, {t, " fetches"}, 64'(fetch_cnt), 64'(efc));
          if (efc == 1)
            chk(last_faddr == BASE + 48'(ea[31:12]) * 8, {t, " R2 fetch addr"},
                64'(last_faddr), 64'(BASE + 48'(ea[31:12]) * 8));
          else
            chk(cyc == ec + 1, {t, " R8 latency"}, 64'(cyc), 64'(ec + 1));
          if (ef) chk(fault_addr == ea, {t, " R7 fault_addr"}, 64'(fault_addr), 64'(ea));
          fetch_cnt = 0;
        end
      end
    end
  end

  task automatic send(input logic [31:0] a, input logic wr, input logic ef,
                      input logic [47:0] eh, input int efc, input string t);
    while (!req_ready) @(negedge clk);
    q_fault.push_back(ef); q_haddr.push_back(eh); q_fetch.push_back(efc);
    q_addr.push_back(a); q_cyc.push_back(cyc); q_tag.push_back(t);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ok_rd(input int p, input logic [11:0] off, input int efc, input string t);
    send({20'(p), off}, 1'b0, 1'b0, {rpn_of(p), off}, efc, t);
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && q_tag.size() != 0; i++) @(negedge clk);
  endtask

  task automatic do_flush(input string t);
    flush_req = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, {t, " R11 ready low in flush"}, 64'(req_ready), 64'h0);
    for (int i = 0; i < 50 && !flush_done; i++) @(negedge clk);
    chk(flush_done == 1'b1, {t, " R11 flush_done"}, 64'(flush_done), 64'h1);
    chk(rcvd == sent, {t, " R11 flush after outstanding read"}, 64'(rcvd), 64'(sent));
    flush_req = 1'b0;
    @(negedge clk);
    chk(flush_done == 1'b0, {t, " R11 done is a pulse"}, 64'(flush_done), 64'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", q_tag.size());
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < 64; p++) tmem[p] = mk(rpn_of(p), BUS, 1'b1, 1'b1);
    tmem[3] = mk(rpn_of(3), BUS, 1'b0, 1'b1);
    tmem[4] = mk(rpn_of(4), BUS, 1'b1, 1'b0);
    tmem[5] = mk(rpn_of(5), BUS, 1'b0, 1'b0);
    tmem[6] = mk(rpn_of(6), 6'h2A, 1'b1, 1'b1);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 rsp_valid", 64'(rsp_valid), 0);
    chk(mem_rd_req == 0, "R1 mem_rd_req", 64'(mem_rd_req), 0);
    chk(flush_done == 0, "R1 flush_done", 64'(flush_done), 0);
    chk(fault_addr == 0, "R1 fault_addr", 64'(fault_addr), 0);
    chk(req_ready == 1, "R1 req_ready", 64'(req_ready), 1);

    ok_rd(1, 12'h123, 1, "R2 R3 R8 miss page1");
    send({20'd1, 12'hFFF}, 1'b1, 1'b0, {rpn_of(1), 12'hFFF}, 0, "R8 hit write page1");
    ok_rd(1, 12'h000, 0, "R8 hit read page1");
    ok_rd(3, 12'h010, 1, "R4 read-only read");
    send({20'd3, 12'h020}, 1'b1, 1'b1, 48'h0, 0, "R4 R7 read-only write cached");
    send({20'd4, 12'h030}, 1'b1, 1'b0, {rpn_of(4), 12'h030}, 1, "R4 write-only write");
    send({20'd4, 12'h040}, 1'b0, 1'b1, 48'h0, 0, "R4 write-only read");
    send({20'd5, 12'h050}, 1'b0, 1'b1, 48'h0, 1, "R4 invalid entry");
    send({20'd5, 12'h060}, 1'b1, 1'b1, 48'h0, 1, "R10 invalid not cached");
    send({20'd6, 12'h070}, 1'b0, 1'b1, 48'h0, 1, "R5 hub mismatch");
    send({20'd40, 12'h080}, 1'b0, 1'b1, 48'h0, 0, "R6 page at limit");
    send({20'hFFFFF, 12'h090}, 1'b1, 1'b1, 48'h0, 0, "R6 top page");
    ok_rd(39, 12'h0A0, 1, "R6 last page in range");
    drain();

    do_flush("flush A");
    for (int p = 10; p < 18; p++) ok_rd(p, 12'h004, 1, "R9 fill");
    ok_rd(10, 12'h008, 0, "R9 oldest still cached");
    ok_rd(18, 12'h00C, 1, "R9 ninth page");
    ok_rd(11, 12'h010, 0, "R9 slot1 kept");
    ok_rd(10, 12'h014, 1, "R9 oldest evicted");
    ok_rd(11, 12'h018, 1, "R9 next victim slot1");
    drain();

    ok_rd(20, 12'h100, 1, "R11 prefill");
    drain();
    tmem[20] = mk(36'h0DEAD_0000, BUS, 1'b1, 1'b1);
    ok_rd(20, 12'h104, 0, "R11 stale hit before flush");
    drain();
    do_flush("flush B");
    send({20'd20, 12'h108}, 1'b0, 1'b0, {36'h0DEAD_0000, 12'h108}, 1, "R11 fresh after flush");

    ok_rd(21, 12'h10C, 1, "R11 miss under flush");
    do_flush("flush C");
    ok_rd(21, 12'h110, 1, "R11 refetch after flush C");
    drain();

    chk(q_tag.size() == 0, "all responses seen", 64'(q_tag.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule